// File: doc/BRIEF.md
# Parallel I/O Port with Edge-Capture Interrupt

This block is a general-purpose parallel I/O port of up to 32 pins that sits behind a small 32-bit register bus. A host uses it to drive output values, to choose per pin whether the pin drives or only listens, and to read the pin levels back. A single interrupt line tells the host that an enabled pin needs attention.

The interrupt trigger is chosen once, when the port is built, by the `TRIGGER` parameter. It cannot be changed at run time. There are four modes:

- **Edge modes (rising, falling or either):** an edge on a synchronised input latches a per-pin capture bit. The bit stays set until the host writes a one to it.
- **Level-high mode:** no capture bits are used. The interrupt follows the masked input levels directly.

The pads are not part of the block. Each pin appears as three separate signals: an input level, an output value and an output enable.

Top module: `gpio_capture_port`

## Requirements
- R1: After reset the output-value, direction, mask and capture registers are all zero, so `pin_out`, `pin_oe` and `irq` are all low.
- R2: The bus word address selects registers as follows: 0 is data, 1 is direction, 2 is interrupt mask and 3 is capture. A read of any word from 4 to 7 returns zero. Read data is registered and valid in the cycle after the strobe.
- R3: A write to word 0 sets `pin_out`. A read of word 0 returns the input levels after a two-flop synchroniser.
- R4: Direction bit i at 1 drives `pin_oe[i]` high, making pin i an output. At 0 the pin is an input. The register reads back as written.
- R5: Register bits at and above `PIN_COUNT` read as zero, and writes to them are ignored.
- R6: In rising mode, a 0-to-1 change on a synchronised input sets that pin's capture bit. A 1-to-0 change does not.
- R7: In falling mode, a 1-to-0 change sets the capture bit. A 0-to-1 change does not.
- R8: In either-edge mode, both directions of change set the capture bit.
- R9: A capture bit stays set until a bus write to word 3 carries a 1 in its position. A 0 in a write to word 3 leaves the bit unchanged.
- R10: If a qualifying edge and a clearing write to the same bit occur in the same cycle, the bit ends up set.
- R11: In edge modes, `irq` is high one cycle after the bitwise AND of capture and mask becomes nonzero, and low one cycle after it becomes zero.
- R12: In level-high mode, `irq` follows, one cycle later, whether the bitwise AND of synchronised inputs and mask is nonzero. The capture register stays zero in this mode.
- R13: A mask bit of 1 enables that pin's interrupt and a mask bit of 0 blocks it. The mask register reads back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_stb | input | 1 | One-cycle access strobe |
| bus_we | input | 1 | 1 = write, 0 = read, qualified by strobe |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | PIN_COUNT | Pin input levels (asynchronous) |
| pin_out | output | PIN_COUNT | Output values |
| pin_oe | output | PIN_COUNT | Output enables |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench builds four copies of the port that share one bus and one set of pins:

- Three copies use `PIN_COUNT` = 12, one in each edge mode (rising, falling and either). With 12 pins, the unused upper register bits can be reached and shown to read as zero and to ignore writes.
- One copy uses the full 32 pins in level-high mode.

Because all four copies see the same pin changes, a single pin change shows side by side which modes latch it and which do not. The rising-mode copy is also used to line up a clearing write with the exact cycle in which an edge is detected.

// File: rtl/gpio_cap_pkg.sv
package gpio_cap_pkg;

    // Interrupt trigger selection, fixed at build time.
    typedef enum logic [1:0] {
        TRIG_RISE  = 2'd0,
        TRIG_FALL  = 2'd1,
        TRIG_BOTH  = 2'd2,
        TRIG_LEVEL = 2'd3
    } trig_mode_e;

    localparam int BUS_W  = 32;
    localparam int WORD_W = 3;

    // Word addresses of the register set.
    localparam logic [WORD_W-1:0] W_DATA = 3'd0;
    localparam logic [WORD_W-1:0] W_DIR  = 3'd1;
    localparam logic [WORD_W-1:0] W_MASK = 3'd2;
    localparam logic [WORD_W-1:0] W_CAPT = 3'd3;

    function automatic logic is_edge_mode(trig_mode_e m);
        return m != TRIG_LEVEL;
    endfunction

endpackage

// File: rtl/gpio_in_sync.sv
// Two-flop synchroniser plus edge qualification for every pin.
module gpio_in_sync
    import gpio_cap_pkg::*;
#(
    parameter int         N       = 32,
    parameter trig_mode_e TRIGGER = TRIG_RISE
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pin_in,
    output logic [N-1:0] level_o,
    output logic [N-1:0] edge_o
);

    logic [N-1:0] meta_q;
    logic [N-1:0] sync_q;
    logic [N-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= pin_in;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign level_o = sync_q;

    // The trigger parameter picks the edge qualifier.
    generate
        case (TRIGGER)
            TRIG_RISE:  begin : g_rise
                assign edge_o = sync_q & ~prev_q;
            end
            TRIG_FALL:  begin : g_fall
                assign edge_o = ~sync_q & prev_q;
            end
            TRIG_BOTH:  begin : g_both
                assign edge_o = sync_q ^ prev_q;
            end
            default:    begin : g_level
                assign edge_o = '0;
            end
        endcase
    endgenerate

endmodule

// File: rtl/gpio_capture_bank.sv
// Per-pin sticky capture bits, cleared by writing ones; set wins.
module gpio_capture_bank #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] edge_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] cap_o
);

    logic [N-1:0] cap_q;

    always_ff @(posedge clk) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= (cap_q & ~clr_i) | edge_i;
    end

    assign cap_o = cap_q;

    // R9: an uncleared bit keeps its value
    a_r9_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((cap_q & $past(cap_q & ~clr_i)) == $past(cap_q & ~clr_i)));

    // R10: a detected edge is never lost, even against a clear
    a_r10_edge_kept: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((cap_q & $past(edge_i)) == $past(edge_i)));

endmodule

// File: rtl/gpio_reg_file.sv
// Bus decode, storage for data/direction/mask, clear strobe and readback.
module gpio_reg_file
    import gpio_cap_pkg::*;
#(
    parameter int N = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_stb,
    input  logic              bus_we,
    input  logic [WORD_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    input  logic [N-1:0]      level_i,
    input  logic [N-1:0]      cap_i,
    output logic [N-1:0]      out_o,
    output logic [N-1:0]      dir_o,
    output logic [N-1:0]      mask_o,
    output logic [N-1:0]      clr_o,
    output logic [BUS_W-1:0]  rdata_o
);

    localparam logic [BUS_W-1:0] PIN_MASK =
        (N >= BUS_W) ? {BUS_W{1'b1}} : ((BUS_W'(1) << N) - BUS_W'(1));

    logic [N-1:0]     out_q, dir_q, mask_q;
    logic [BUS_W-1:0] rdata_q;
    logic [N-1:0]     read_sel;
    logic [BUS_W-1:0] read_ext;
    logic             read_hit;
    logic             wr_en, rd_en;

    assign wr_en = bus_stb &  bus_we;
    assign rd_en = bus_stb & ~bus_we;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q  <= '0;
            dir_q  <= '0;
            mask_q <= '0;
        end else if (wr_en) begin
            if (bus_addr == W_DATA) out_q  <= bus_wdata[N-1:0];
            if (bus_addr == W_DIR)  dir_q  <= bus_wdata[N-1:0];
            if (bus_addr == W_MASK) mask_q <= bus_wdata[N-1:0];
        end
    end

    assign clr_o = (wr_en && bus_addr == W_CAPT) ? bus_wdata[N-1:0] : '0;

    always_comb begin
        read_hit = 1'b1;
        unique case (bus_addr)
            W_DATA:  read_sel = level_i;
            W_DIR:   read_sel = dir_q;
            W_MASK:  read_sel = mask_q;
            W_CAPT:  read_sel = cap_i;
            default: begin
                read_sel = '0;
                read_hit = 1'b0;
            end
        endcase
        read_ext         = '0;
        read_ext[N-1:0]  = read_hit ? read_sel : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     rdata_q <= '0;
        else if (rd_en) rdata_q <= read_ext;
    end

    assign out_o   = out_q;
    assign dir_o   = dir_q;
    assign mask_o  = mask_q;
    assign rdata_o = rdata_q;

    // R2: unmapped words read as zero
    a_r2_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && bus_addr > W_CAPT) |=> (rdata_o == '0));

    // R5: nothing above the pin count ever reaches the bus
    a_r5_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ((rdata_o & ~PIN_MASK) == '0));

    // R4: direction follows the last write
    a_r4_dir_written: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && bus_addr == W_DIR) |=> (dir_o == $past(bus_wdata[N-1:0])));

endmodule

// File: rtl/gpio_capture_port.sv
// Top: parallel I/O port with build-time interrupt trigger mode.
module gpio_capture_port
    import gpio_cap_pkg::*;
#(
    parameter int         PIN_COUNT = 32,
    parameter trig_mode_e TRIGGER   = TRIG_RISE
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_stb,
    input  logic                 bus_we,
    input  logic [2:0]           bus_addr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    input  logic [PIN_COUNT-1:0] pin_in,
    output logic [PIN_COUNT-1:0] pin_out,
    output logic [PIN_COUNT-1:0] pin_oe,
    output logic                 irq
);

    localparam logic EDGE_MODE = is_edge_mode(TRIGGER);

    logic [PIN_COUNT-1:0] level_w, edge_w, cap_w, clr_w, mask_w;
    logic                 irq_d, irq_q;

    gpio_in_sync #(.N(PIN_COUNT), .TRIGGER(TRIGGER)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_in  (pin_in),
        .level_o (level_w),
        .edge_o  (edge_w)
    );

    gpio_capture_bank #(.N(PIN_COUNT)) u_capt (
        .clk    (clk),
        .rst_n  (rst_n),
        .edge_i (edge_w),
        .clr_i  (clr_w),
        .cap_o  (cap_w)
    );

    gpio_reg_file #(.N(PIN_COUNT)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_stb   (bus_stb),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .level_i   (level_w),
        .cap_i     (cap_w),
        .out_o     (pin_out),
        .dir_o     (pin_oe),
        .mask_o    (mask_w),
        .clr_o     (clr_w),
        .rdata_o   (bus_rdata)
    );

    generate
        if (EDGE_MODE) begin : g_irq_edge
            assign irq_d = |(cap_w & mask_w);
        end else begin : g_irq_level
            assign irq_d = |(level_w & mask_w);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= irq_d;
    end

    assign irq = irq_q;

    generate
        if (EDGE_MODE) begin : g_chk_edge
            // R11: interrupt tracks masked capture one cycle later
            a_r11_irq_capture: assert property (@(posedge clk) disable iff (!rst_n)
                1'b1 |=> (irq == $past(|(cap_w & mask_w))));
        end else begin : g_chk_level
            // R12: interrupt tracks masked levels; capture stays idle
            a_r12_irq_level: assert property (@(posedge clk) disable iff (!rst_n)
                1'b1 |=> (irq == $past(|(level_w & mask_w))));
            a_r12_capture_idle: assert property (@(posedge clk) disable iff (!rst_n)
                (cap_w == '0));
        end
    endgenerate

endmodule

// File: tb/gpio_capture_port_tb.sv
module gpio_capture_port_tb;
    import gpio_cap_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_stb = 1'b0;
    logic        bus_we = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] pin_in = '0;

    logic [31:0] rd_r, rd_f, rd_b, rd_l;
    logic [11:0] out_r, oe_r, out_f, oe_f, out_b, oe_b;
    logic [31:0] out_l, oe_l;
    logic        irq_r, irq_f, irq_b, irq_l;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    gpio_capture_port #(.PIN_COUNT(12), .TRIGGER(TRIG_RISE)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_stb(bus_stb), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rd_r),
        .pin_in(pin_in[11:0]), .pin_out(out_r), .pin_oe(oe_r), .irq(irq_r));

    gpio_capture_port #(.PIN_COUNT(12), .TRIGGER(TRIG_FALL)) u_fall (
        .clk(clk), .rst_n(rst_n), .bus_stb(bus_stb), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rd_f),
        .pin_in(pin_in[11:0]), .pin_out(out_f), .pin_oe(oe_f), .irq(irq_f));

    gpio_capture_port #(.PIN_COUNT(12), .TRIGGER(TRIG_BOTH)) u_both (
        .clk(clk), .rst_n(rst_n), .bus_stb(bus_stb), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rd_b),
        .pin_in(pin_in[11:0]), .pin_out(out_b), .pin_oe(oe_b), .irq(irq_b));

    gpio_capture_port #(.PIN_COUNT(32), .TRIGGER(TRIG_LEVEL)) u_lvl (
        .clk(clk), .rst_n(rst_n), .bus_stb(bus_stb), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rd_l),
        .pin_in(pin_in), .pin_out(out_l), .pin_oe(oe_l), .irq(irq_l));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
        bus_stb = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_stb = 1'b0; bus_we = 1'b0;
    endtask

    // After return, rd_* hold the registered read data.
    task automatic bus_read(input logic [2:0] a);
        bus_stb = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_stb = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 pin_out", 32'(out_r), 32'h0);
        chk("R1 pin_oe", 32'(oe_r), 32'h0);
        chk("R1 irq", {irq_r, irq_f, irq_b, irq_l}, 32'h0);
        bus_read(W_DIR);  chk("R1 dir", rd_r, 32'h0);
        bus_read(W_MASK); chk("R1 mask", rd_r, 32'h0);
        bus_read(W_CAPT); chk("R1 capture", rd_r, 32'h0);
    endtask

    task automatic t_regs;
        bus_write(W_DIR, 32'h0000_0A5A);
        chk("R4 pin_oe", 32'(oe_r), 32'h0A5A);
        bus_read(W_DIR);  chk("R4 dir readback", rd_r, 32'h0A5A);
        bus_write(W_MASK, 32'h0000_03C3);
        bus_read(W_MASK); chk("R13 mask readback", rd_r, 32'h03C3);
        bus_write(W_DATA, 32'h0000_05F0);
        chk("R3 pin_out", 32'(out_r), 32'h05F0);
        bus_write(W_DIR, 32'hFFFF_FFFF);
        bus_read(W_DIR);
        chk("R5 upper dir 12-pin", rd_r, 32'h0000_0FFF);
        chk("R5 full dir 32-pin", rd_l, 32'hFFFF_FFFF);
        bus_write(W_DIR, 32'h0);
        bus_write(W_MASK, 32'h0);
        bus_write(W_DATA, 32'h0);
    endtask

    task automatic t_data_unmapped;
        pin_in = 32'hABCD_E123;
        wait_cyc(4);
        bus_read(W_DATA);
        chk("R3 level read 12-pin", rd_r, 32'h0000_0123);
        chk("R3 level read 32-pin", rd_l, 32'hABCD_E123);
        bus_read(3'd5);
        chk("R2 unmapped word 5", rd_l, 32'h0);
        bus_read(3'd7);
        chk("R2 unmapped word 7", rd_r, 32'h0);
        pin_in = 32'h0;
        wait_cyc(4);
        bus_write(W_CAPT, 32'hFFFF_FFFF);
    endtask

    task automatic t_rise;
        pin_in[3] = 1'b1;
        wait_cyc(6);
        bus_read(W_CAPT);
        chk("R6 rise captured", rd_r, 32'h008);
        chk("R7 rise ignored by falling", rd_f, 32'h0);
        chk("R8 rise captured by both", rd_b, 32'h008);
        chk("R12 level capture idle", rd_l, 32'h0);
        chk("R13 masked no irq", {irq_r, irq_b}, 32'h0);
        bus_write(W_MASK, 32'h008);
        wait_cyc(2);
        chk("R11 irq rising", 32'(irq_r), 32'h1);
        chk("R11 irq falling quiet", 32'(irq_f), 32'h0);
        chk("R12 level irq high", 32'(irq_l), 32'h1);
    endtask

    task automatic t_fall;
        pin_in[3] = 1'b0;
        wait_cyc(6);
        bus_read(W_CAPT);
        chk("R7 fall captured", rd_f, 32'h008);
        chk("R6 fall ignored, bit held", rd_r, 32'h008);
        chk("R11 irq falling", 32'(irq_f), 32'h1);
        chk("R12 level irq low", 32'(irq_l), 32'h0);
    endtask

    task automatic t_w1c;
        bus_write(W_CAPT, 32'h0000_0FF7);
        bus_read(W_CAPT);
        chk("R9 write zero keeps bit", rd_r, 32'h008);
        bus_write(W_CAPT, 32'h008);
        bus_read(W_CAPT);
        chk("R9 write one clears", rd_r, 32'h0);
        chk("R8 both cleared", rd_b, 32'h0);
        wait_cyc(1);
        chk("R11 irq drops", {irq_r, irq_b}, 32'h0);
    endtask

    task automatic t_race;
        pin_in[3] = 1'b1;
        wait_cyc(6);
        pin_in[3] = 1'b0;
        wait_cyc(6);
        bus_read(W_CAPT);
        chk("R10 setup bit set", rd_r, 32'h008);
        // Edge qualified between the 2nd and 3rd edges after the change.
        pin_in[3] = 1'b1;
        wait_cyc(2);
        bus_write(W_CAPT, 32'h008);
        bus_read(W_CAPT);
        chk("R10 edge beats clear", rd_r, 32'h008);
        bus_write(W_CAPT, 32'hFFFF_FFFF);
        bus_read(W_CAPT);
        chk("R9 clear after race", rd_r, 32'h0);
    endtask

    task automatic t_level_mask;
        bus_write(W_MASK, 32'h0);
        pin_in = 32'h8000_00F0;
        wait_cyc(5);
        chk("R13 level masked off", 32'(irq_l), 32'h0);
        bus_write(W_MASK, 32'h8000_0000);
        wait_cyc(2);
        chk("R12 level top pin", 32'(irq_l), 32'h1);
        bus_write(W_MASK, 32'h0000_0F00);
        wait_cyc(2);
        chk("R12 level disjoint mask", 32'(irq_l), 32'h0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog (all requirements) actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(1);
        t_reset();
        t_regs();
        t_data_unmapped();
        t_rise();
        t_fall();
        t_w1c();
        t_race();
        t_level_mask();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule